// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO Buffer

This block carries 18-bit words from one clock domain to another through a 256-word store. The producer and the consumer each run on their own free-running clock. The two clocks may be unrelated, or they may be one and the same net. The producer presents a word and qualifies it with two enables of opposite polarity. It may only push while its ready flag is high.

On the consumer side, the oldest word is placed in an output register without any request. A valid flag says when that register holds data. The consumer removes the displayed word by pulling its read enable and both output qualifiers low.

Two occupancy indicators are also provided. One reports more than half full. The other reports nearly empty or nearly full, within a programmable margin. The margin can be reloaded from the data bus through a separate active-low strobe.

Top module: `dualclk_fwft_fifo`

## Requirements
- R1: A word is stored on a rising `wrClk` edge only if `wrEnHi`=1, `wrEnLo`=0, `inReady`=1 and `progEnN`=1. Any other combination stores nothing.
- R2: The first word written into an empty buffer appears on `rdData`, and `outReady` rises, with no action on `rdEnN`, `oeN1` or `oeN2`.
- R3: The displayed word is consumed on a rising `rdClk` edge only if `rdEnN`, `oeN1` and `oeN2` are all 0 and `outReady` is 1. Otherwise `rdData` holds its value.
- R4: Words leave in the order they entered. Exactly 256 words fit, and the word held in the output register counts toward them. `inReady` is 0 at 256 words, and a push attempted then is discarded.
- R5: When the last stored word is consumed, `outReady` falls on that same `rdClk` edge.
- R6: While `resetIn` is high, `inReady`, `outReady` and `halfFull` are 0 and `almostFlag` is 1. A few `wrClk` edges after release, `inReady` is 1. Reset must span at least four edges of each clock.
- R7: `halfFull` is 1 when the occupancy is 129 words or more, and 0 otherwise.
- R8: `almostFlag` is 1 when the occupancy is at most the margin, or at least 256 minus the margin. After reset the margin is 32.
- R9: A `wrClk` edge with `progEnN`=0 loads `wrData[7:0]` as the new margin and stores no word.
- R10: All of the above holds when `rdClk` and `wrClk` are the same clock, including a push and a pop on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Producer clock |
| rdClk | input | 1 | Consumer clock |
| resetIn | input | 1 | Asynchronous reset, active high |
| wrData | input | 18 | Word to push; bits 7:0 also carry a new margin |
| wrEnHi | input | 1 | Push enable, active high |
| wrEnLo | input | 1 | Push enable, active low |
| progEnN | input | 1 | Margin load strobe, active low |
| inReady | output | 1 | Room available (producer domain) |
| rdData | output | 18 | Output register |
| rdEnN | input | 1 | Pop enable, active low |
| oeN1 | input | 1 | Pop qualifier, active low |
| oeN2 | input | 1 | Pop qualifier, active low |
| outReady | output | 1 | Output register valid (consumer domain) |
| halfFull | output | 1 | Occupancy of 129 or more |
| almostFlag | output | 1 | Occupancy within the margin of empty or of full |

## Verification
Some properties are checked on every clock edge:
- occupancy never goes past 256;
- the producer pointer never moves while `inReady` is low;
- the Gray-coded pointer changes by at most one bit per edge;
- `outReady` only falls on an edge that consumed a word;
- `rdData` holds while any pop qualifier is high;
- the flag values during reset.

Other behaviour only the directed scenarios can show:
- data order across a full fill and drain;
- fall-through of the first word;
- the exact occupancy thresholds of `halfFull` and `almostFlag` at the default margin and at a reprogrammed one;
- operation with a single shared clock.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 18;
  localparam int OFS_W   = 8;
  localparam int SYNC_N  = 2;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PTR_W   = ADDR_W + 1;
  localparam int HALF_AT = DEPTH / 2 + 1;
  localparam logic [OFS_W-1:0] OFS_RESET = OFS_W'(32);

  typedef struct packed {
    logic              memWrite;
    logic [ADDR_W-1:0] wrAddr;
    logic              outLoad;
    logic [ADDR_W-1:0] rdAddr;
  } strobe_t;

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int   WIDTH  = 1,
  parameter int   STAGES = 2,
  parameter logic RSTBIT = 1'b0
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= {WIDTH{RSTBIT}};
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/xfifo_dpath.sv
module xfifo_dpath
  import xfifo_pkg::*;
(
  input  logic              wrClk,
  input  logic              rdClk,
  input  strobe_t           str,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (str.memWrite) store[str.wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (str.outLoad) rdData <= store[str.rdAddr];
  end
endmodule

// File: rtl/xfifo_ctrl.sv
module xfifo_ctrl
  import xfifo_pkg::*;
(
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             resetIn,
  input  logic             wrEnHi,
  input  logic             wrEnLo,
  input  logic             progEnN,
  input  logic [OFS_W-1:0] ofsIn,
  input  logic             rdEnN,
  input  logic             oeN1,
  input  logic             oeN2,
  output strobe_t          str,
  output logic             inReady,
  output logic             outReady,
  output logic             halfFull,
  output logic             almostFlag
);
  logic             wrRst, rdRst;
  logic [PTR_W-1:0] wrPtr, wrGray, wrPtrNext, wrGrayNext, occNext;
  logic [PTR_W-1:0] doneSyncGray, doneSyncBin;
  logic [PTR_W-1:0] rdPtr, donePtr, doneGray, wrSyncGray, wrSyncBin;
  logic [OFS_W-1:0] ofsReg;
  logic             doWrite, fullNext, outValid, memHasData, consume, load;

  // reset release is synchronised per domain; assertion stays asynchronous
  xfifo_sync #(.WIDTH(1), .STAGES(SYNC_N), .RSTBIT(1'b1)) wrRstSync (
    .clk(wrClk), .arst(resetIn), .d(1'b0), .q(wrRst));
  xfifo_sync #(.WIDTH(1), .STAGES(SYNC_N), .RSTBIT(1'b1)) rdRstSync (
    .clk(rdClk), .arst(resetIn), .d(1'b0), .q(rdRst));

  // Gray pointers crossing domains
  xfifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_N), .RSTBIT(1'b0)) doneToWr (
    .clk(wrClk), .arst(wrRst), .d(doneGray), .q(doneSyncGray));
  xfifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_N), .RSTBIT(1'b0)) wrToRd (
    .clk(rdClk), .arst(rdRst), .d(wrGray), .q(wrSyncGray));

  // ---------------- write domain ----------------
  assign doneSyncBin = gray2bin(doneSyncGray);
  assign doWrite     = wrEnHi & ~wrEnLo & inReady & progEnN;
  assign wrPtrNext   = wrPtr + PTR_W'(doWrite);
  assign wrGrayNext  = bin2gray(wrPtrNext);
  assign occNext     = wrPtrNext - doneSyncBin;
  assign fullNext    = (wrGrayNext == {~doneSyncGray[PTR_W-1:PTR_W-2],
                                       doneSyncGray[PTR_W-3:0]});

  always_ff @(posedge wrClk or posedge wrRst) begin
    if (wrRst) begin
      wrPtr      <= '0;
      wrGray     <= '0;
      inReady    <= 1'b0;
      halfFull   <= 1'b0;
      almostFlag <= 1'b1;
      ofsReg     <= OFS_RESET;
    end else begin
      wrPtr      <= wrPtrNext;
      wrGray     <= wrGrayNext;
      inReady    <= ~fullNext;
      halfFull   <= (occNext >= PTR_W'(HALF_AT));
      almostFlag <= (occNext <= PTR_W'(ofsReg)) ||
                    (occNext >= PTR_W'(DEPTH) - PTR_W'(ofsReg));
      if (!progEnN) ofsReg <= ofsIn;
    end
  end

  // ---------------- read domain ----------------
  assign wrSyncBin  = gray2bin(wrSyncGray);
  assign memHasData = (rdPtr != wrSyncBin);
  assign consume    = outValid & ~rdEnN & ~oeN1 & ~oeN2;
  assign load       = memHasData & (~outValid | consume);

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      rdPtr    <= '0;
      donePtr  <= '0;
      doneGray <= '0;
      outValid <= 1'b0;
    end else begin
      rdPtr    <= rdPtr + PTR_W'(load);
      donePtr  <= donePtr + PTR_W'(consume);
      doneGray <= bin2gray(donePtr + PTR_W'(consume));
      outValid <= load | (outValid & ~consume);
    end
  end

  assign outReady     = outValid;
  assign str.memWrite = doWrite;
  assign str.wrAddr   = wrPtr[ADDR_W-1:0];
  assign str.outLoad  = load;
  assign str.rdAddr   = rdPtr[ADDR_W-1:0];

  // R4
  occ_bound_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrPtr - doneSyncBin) <= PTR_W'(DEPTH));

  // R4
  gray_step_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  // R1
  blocked_push_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    !inReady |=> (wrPtr == $past(wrPtr)));

  // R6
  reset_flags_chk: assert property (@(posedge wrClk)
    wrRst |-> (!inReady && !halfFull && almostFlag));

  // R5
  ready_fall_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    $fell(outValid) |-> $past(consume));

  // R3
  done_hold_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    !consume |=> $stable(donePtr));
endmodule

// File: rtl/dualclk_fwft_fifo.sv
module dualclk_fwft_fifo
  import xfifo_pkg::*;
(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              resetIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEnHi,
  input  logic              wrEnLo,
  input  logic              progEnN,
  output logic              inReady,
  output logic [DATA_W-1:0] rdData,
  input  logic              rdEnN,
  input  logic              oeN1,
  input  logic              oeN2,
  output logic              outReady,
  output logic              halfFull,
  output logic              almostFlag
);
  strobe_t str;

  xfifo_ctrl ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .resetIn(resetIn),
    .wrEnHi(wrEnHi), .wrEnLo(wrEnLo), .progEnN(progEnN),
    .ofsIn(wrData[OFS_W-1:0]),
    .rdEnN(rdEnN), .oeN1(oeN1), .oeN2(oeN2),
    .str(str), .inReady(inReady), .outReady(outReady),
    .halfFull(halfFull), .almostFlag(almostFlag));

  xfifo_dpath dpath (
    .wrClk(wrClk), .rdClk(rdClk), .str(str),
    .wrData(wrData), .rdData(rdData));

  // R3
  out_hold_chk: assert property (@(posedge rdClk) disable iff (resetIn)
    (outReady && (rdEnN || oeN1 || oeN2)) |=> $stable(rdData));
endmodule

// File: tb/dualclk_fwft_fifo_test.sv
module dualclk_fwft_fifo_test;
  logic        wrClk = 1'b0, rdFree = 1'b0, sameClk = 1'b0, rdClk;
  logic        resetIn = 1'b1;
  logic [17:0] wrData = '0;
  logic        wrEnHi = 1'b0, wrEnLo = 1'b1, progEnN = 1'b1;
  logic        rdEnN = 1'b1, oeN1 = 1'b0, oeN2 = 1'b0;
  logic        inReady, outReady, halfFull, almostFlag;
  logic [17:0] rdData;
  int          vectors = 0, fails = 0, wrSeq = 0, rdSeq = 0;
  bit          finished = 1'b0;

  always #5 wrClk = ~wrClk;
  always #6.5 rdFree = ~rdFree;
  assign rdClk = sameClk ? wrClk : rdFree;

  dualclk_fwft_fifo uut (
    .wrClk(wrClk), .rdClk(rdClk), .resetIn(resetIn), .wrData(wrData),
    .wrEnHi(wrEnHi), .wrEnLo(wrEnLo), .progEnN(progEnN), .inReady(inReady),
    .rdData(rdData), .rdEnN(rdEnN), .oeN1(oeN1), .oeN2(oeN2),
    .outReady(outReady), .halfFull(halfFull), .almostFlag(almostFlag));

  function automatic logic [17:0] word(input int n);
    return 18'((n * 37 + 5) ^ (n << 9));
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wrClk);
    repeat (8) @(negedge rdClk);
  endtask

  task automatic applyReset();
    resetIn = 1'b1;
    wrEnHi = 1'b0; wrEnLo = 1'b1; progEnN = 1'b1;
    rdEnN = 1'b1; oeN1 = 1'b0; oeN2 = 1'b0;
    repeat (6) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
    check(!inReady && !outReady && !halfFull && almostFlag, "R6 flags in reset",
          {inReady, outReady, halfFull, almostFlag}, 4'b0001);
    resetIn = 1'b0;
    repeat (8) @(negedge wrClk);
    check(inReady, "R6 inReady after release", inReady, 1);
    wrSeq = 0;
    rdSeq = 0;
  endtask

  task automatic writeWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrData = word(wrSeq);
      wrEnHi = 1'b1;
      wrEnLo = 1'b0;
      wrSeq++;
    end
    @(negedge wrClk);
    wrEnHi = 1'b0;
    wrEnLo = 1'b1;
  endtask

  task automatic readWords(input int n, input string req);
    int count = 0, bad = 0, guard = 0;
    @(negedge rdClk);
    rdEnN = 1'b0;
    while (count < n && guard < 4000) begin
      if (outReady) begin
        if (rdData !== word(rdSeq)) bad++;
        rdSeq++;
        count++;
      end
      if (count < n) begin
        @(negedge rdClk);
        guard++;
      end
    end
    @(negedge rdClk);
    rdEnN = 1'b1;
    check(bad == 0 && count == n, req, bad + (n - count), 0);
  endtask

  task automatic testFallThrough();
    writeWords(1);
    repeat (8) @(negedge rdClk);
    check(outReady, "R2 outReady without read", outReady, 1);
    check(rdData == word(0), "R2 first word shown", rdData, word(0));
    @(negedge rdClk); rdEnN = 1'b0; oeN1 = 1'b1;
    repeat (3) @(negedge rdClk); oeN1 = 1'b0; oeN2 = 1'b1;
    repeat (3) @(negedge rdClk); oeN2 = 1'b0; rdEnN = 1'b1;
    repeat (3) @(negedge rdClk);
    check(outReady && rdData == word(0), "R3 partial qualifiers hold word",
          {outReady, rdData}, {1'b1, word(0)});
    readWords(1, "R3 word consumed");
    check(!outReady, "R5 outReady drops after last read", outReady, 0);
  endtask

  task automatic testQualify();
    @(negedge wrClk); wrData = 18'h3ABC; wrEnHi = 1'b1; wrEnLo = 1'b1;
    @(negedge wrClk); wrEnHi = 1'b0; wrEnLo = 1'b0;
    @(negedge wrClk); wrEnHi = 1'b0; wrEnLo = 1'b1;
    settle();
    check(!outReady, "R1 unqualified pushes ignored", outReady, 0);
    writeWords(1);
    settle();
    readWords(1, "R1 qualified push stored");
    settle();
    check(!outReady, "R1 only one word stored", outReady, 0);
  endtask

  task automatic testFillFlags();
    writeWords(32);  settle();
    check(almostFlag, "R8 occ 32 near empty", almostFlag, 1);
    writeWords(1);   settle();
    check(!almostFlag && !halfFull, "R8 occ 33 clear", {almostFlag, halfFull}, 0);
    writeWords(95);  settle();
    check(!halfFull, "R7 occ 128", halfFull, 0);
    writeWords(1);   settle();
    check(halfFull, "R7 occ 129", halfFull, 1);
    writeWords(94);  settle();
    check(!almostFlag, "R8 occ 223", almostFlag, 0);
    writeWords(1);   settle();
    check(almostFlag, "R8 occ 224 near full", almostFlag, 1);
    writeWords(32);  settle();
    check(!inReady, "R4 full at 256 incl output register", inReady, 0);
    @(negedge wrClk); wrData = 18'h2AAAA; wrEnHi = 1'b1; wrEnLo = 1'b0;
    repeat (3) @(negedge wrClk);
    wrEnHi = 1'b0; wrEnLo = 1'b1;
    readWords(256, "R4 order over full drain");
    settle();
    check(!outReady, "R4 push while full discarded", outReady, 0);
    check(!halfFull && almostFlag, "R7 R8 flags after drain",
          {halfFull, almostFlag}, 2'b01);
  endtask

  task automatic testProgram();
    @(negedge wrClk); progEnN = 1'b0; wrData = 18'd10; wrEnHi = 1'b1; wrEnLo = 1'b0;
    @(negedge wrClk); progEnN = 1'b1; wrEnHi = 1'b0; wrEnLo = 1'b1;
    settle();
    check(!outReady, "R9 margin load stores no word", outReady, 0);
    writeWords(10);  settle();
    check(almostFlag, "R9 occ 10 at margin 10", almostFlag, 1);
    writeWords(1);   settle();
    check(!almostFlag, "R9 occ 11 at margin 10", almostFlag, 0);
    writeWords(234); settle();
    check(!almostFlag, "R9 occ 245 at margin 10", almostFlag, 0);
    writeWords(1);   settle();
    check(almostFlag, "R9 occ 246 at margin 10", almostFlag, 1);
    readWords(246, "R9 data intact");
  endtask

  task automatic testSameClock();
    sameClk = 1'b1;
    applyReset();
    writeWords(5);
    settle();
    check(outReady && rdData == word(0), "R10 fall-through on shared clock",
          rdData, word(0));
    readWords(5, "R10 order on shared clock");
    fork
      writeWords(20);
      readWords(20, "R10 concurrent push and pop");
    join
    settle();
    check(!outReady, "R10 empty after concurrent traffic", outReady, 0);
  endtask

  initial begin
    applyReset();
    testFallThrough();
    testQualify();
    testFillFlags();
    testProgram();
    testSameClock();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule